// File: doc/BRIEF.md
# Receive Elastic Buffer with Status

This block absorbs the small rate difference between a recovered receive clock and the local user clock. Data words enter on the write clock when `wr_en` is high and leave on the read clock when `rd_en` is high. Each pointer is carried across to the other clock as a Gray code through two flops. The read side works out the fill level from the synchronized write pointer. From that level it produces a registered 3-bit status code. The code reports a level below a minimum latency, a level above a maximum latency, or a latched overflow or underflow.

After any buffer reset the write pointer starts half the depth ahead of the read pointer, so the buffer opens at its centre. A reset comes either from the asynchronous `buf_rst` input or, when the `AUTO_RST` parameter is set, from an internal idle timer. The timer fires once after `line_ok` has stayed low for `IDLE_LIMIT` consecutive write-clock cycles. In each clock domain the reset takes effect at once and is released on a clock edge.

When the `BYPASS` parameter is set, the input word appears directly on the output and the status stays at 000.

Top module: `rx_elastic_buf`

## Requirements
- R1: With no latched error and a fill level from MIN_LAT to MAX_LAT inclusive, `rd_status` is 3'b000.
- R2: With no latched error and a fill level below MIN_LAT, `rd_status` is 3'b001.
- R3: With no latched error and a fill level above MAX_LAT, `rd_status` is 3'b010.
- R4: A write while the buffer holds DEPTH words is discarded and latches overflow. Overflow shows as 3'b110 and holds through later reads and writes until the buffer is reset.
- R5: A read while the buffer is empty leaves the read pointer where it is and latches underflow. Underflow shows as 3'b101 and holds until the buffer is reset.
- R6: Error codes win over threshold codes, and overflow (3'b110) wins over underflow (3'b101). No code outside {000, 001, 010, 101, 110} ever appears.
- R7: A pulse on `buf_rst` clears both latched errors and sets the fill level to DEPTH/2. With the default thresholds the status then reads 3'b000, and `rd_data` reads 0 after reset.
- R8: Words come out in the order they went in, including across pointer wrap-around.
- R9: With AUTO_RST set, `line_ok` held low for IDLE_LIMIT consecutive write-clock cycles resets the buffer exactly as `buf_rst` does.
- R10: A low period on `line_ok` shorter than IDLE_LIMIT causes no reset. One unbroken low period causes only one reset, however long it lasts.
- R11: With BYPASS set, `rd_data` equals `wr_data` and `rd_status` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| buf_rst | input | 1 | Asynchronous buffer reset, active high |
| wr_clk | input | 1 | Recovered (write) clock |
| line_ok | input | 1 | Valid line signal present, write-clock domain |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Word to write |
| rd_clk | input | 1 | User (read) clock |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Word read, registered |
| rd_status | output | 3 | Coded fill level and error status |

## Verification
Two functions can fall in the same cycle. A latched error can coincide with a fill-level threshold, and overflow can coincide with underflow. The bench provokes both overlaps. It overflows a full buffer, which is above MAX_LAT. It underflows an empty one, which is below MIN_LAT. It then drains an overflowed buffer until it also underflows. In each case the status must show the higher-priority error code. The idle timer is also exercised while an overflow is latched: a short idle period must leave the error in place, and a full one must clear it exactly once.

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf #(
  parameter int         DW         = 8,
  parameter int         AW         = 3,
  parameter int         MIN_LAT    = 2,
  parameter int         MAX_LAT    = 6,
  parameter bit         BYPASS     = 1'b0,
  parameter bit         AUTO_RST   = 1'b1,
  parameter logic [3:0] IDLE_LIMIT = 4'd8
) (
  input  logic          buf_rst,
  input  logic          wr_clk,
  input  logic          line_ok,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_clk,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    rd_status
);
  localparam int         DEPTH   = 1 << AW;
  localparam logic [AW:0] HALF    = {2'b01, {(AW-1){1'b0}}};
  localparam logic [AW:0] DEPTH_P = {1'b1, {AW{1'b0}}};
  localparam logic [AW:0] MIN_P   = MIN_LAT[AW:0];
  localparam logic [AW:0] MAX_P   = MAX_LAT[AW:0];
  localparam logic [3:0]  IDLE_TC = IDLE_LIMIT - 4'd1;

  if (AW < 2 || MIN_LAT > MAX_LAT || MAX_LAT > DEPTH || IDLE_LIMIT == 4'd0) begin : g_bad_cfg
    $error("rx_elastic_buf: illegal parameter set");
  end

  function automatic logic [AW:0] b2g(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // idle timer, cleared only by the external reset
  logic [1:0] idl_sync;
  logic       idl_rst_n;
  logic [3:0] idle_cnt;
  logic       auto_pulse;

  always_ff @(posedge wr_clk or posedge buf_rst)
    if (buf_rst) idl_sync <= 2'b00;
    else         idl_sync <= {idl_sync[0], 1'b1};
  assign idl_rst_n = idl_sync[1];

  always_ff @(posedge wr_clk or negedge idl_rst_n)
    if (!idl_rst_n) begin
      idle_cnt   <= '0;
      auto_pulse <= 1'b0;
    end else begin
      if (line_ok)                    idle_cnt <= '0;
      else if (idle_cnt != IDLE_LIMIT) idle_cnt <= idle_cnt + 4'd1;
      auto_pulse <= AUTO_RST && !line_ok && (idle_cnt == IDLE_TC);
    end

  p_single_pulse_r10: assert property (@(posedge wr_clk) disable iff (!idl_rst_n)
    auto_pulse |=> !auto_pulse);

  // per-domain reset: immediate assert, clocked release
  wire rst_any = buf_rst | auto_pulse;
  logic [1:0] wrs, rrs;
  logic       wr_rst_n, rd_rst_n;

  always_ff @(posedge wr_clk or posedge rst_any)
    if (rst_any) wrs <= 2'b00;
    else         wrs <= {wrs[0], 1'b1};
  always_ff @(posedge rd_clk or posedge rst_any)
    if (rst_any) rrs <= 2'b00;
    else         rrs <= {rrs[0], 1'b1};
  assign wr_rst_n = wrs[1];
  assign rd_rst_n = rrs[1];

  // storage
  logic [DW-1:0] mem [DEPTH];

  // write side
  logic [AW:0] wptr, wgray, rg1, rg2, rgray;
  logic        ovf_w;
  wire  [AW:0] wnext = wptr + 1'b1;
  wire  [AW:0] rbin_w = g2b(rg2);
  wire         full = (wptr - rbin_w) == DEPTH_P;

  always_ff @(posedge wr_clk or negedge wr_rst_n)
    if (!wr_rst_n) begin
      wptr  <= HALF;
      wgray <= b2g(HALF);
      rg1   <= '0;
      rg2   <= '0;
      ovf_w <= 1'b0;
    end else begin
      rg1 <= rgray;
      rg2 <= rg1;
      if (wr_en) begin
        if (full) ovf_w <= 1'b1;
        else begin
          wptr  <= wnext;
          wgray <= b2g(wnext);
        end
      end
    end

  always_ff @(posedge wr_clk)
    if (wr_rst_n && wr_en && !full) mem[wptr[AW-1:0]] <= wr_data;

  p_ovf_sticky_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    ovf_w |=> ovf_w);
  p_full_drop_r4: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_en && full) |=> $stable(wptr));

  // read side
  logic [AW:0]   rptr, wg1, wg2;
  logic          udf_r, of1, of2;
  logic [2:0]    st;
  logic [DW-1:0] rq;
  wire  [AW:0]   rnext = rptr + 1'b1;
  wire  [AW:0]   occ = g2b(wg2) - rptr;
  wire           empty = (occ == '0);

  always_ff @(posedge rd_clk or negedge rd_rst_n)
    if (!rd_rst_n) begin
      rptr  <= '0;
      rgray <= '0;
      wg1   <= b2g(HALF);
      wg2   <= b2g(HALF);
      udf_r <= 1'b0;
      of1   <= 1'b0;
      of2   <= 1'b0;
      st    <= 3'b000;
      rq    <= '0;
    end else begin
      wg1 <= wgray;
      wg2 <= wg1;
      of1 <= ovf_w;
      of2 <= of1;
      if (rd_en) begin
        if (empty) udf_r <= 1'b1;
        else begin
          rptr  <= rnext;
          rgray <= b2g(rnext);
          rq    <= mem[rptr[AW-1:0]];
        end
      end
      if (of2)              st <= 3'b110;
      else if (udf_r)       st <= 3'b101;
      else if (occ < MIN_P) st <= 3'b001;
      else if (occ > MAX_P) st <= 3'b010;
      else                  st <= 3'b000;
    end

  p_udf_sticky_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    udf_r |=> udf_r);
  p_empty_hold_r5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && empty) |=> $stable(rptr));
  p_ovf_wins_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    of2 |=> (st == 3'b110));
  p_udf_code_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (udf_r && !of2) |=> (st == 3'b101));
  p_legal_code_r6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (st == 3'b000) || (st == 3'b001) || (st == 3'b010) || (st == 3'b101) || (st == 3'b110));

  if (BYPASS) begin : g_bypass
    assign rd_data   = wr_data;
    assign rd_status = 3'b000;
  end else begin : g_buffer
    assign rd_data   = rq;
    assign rd_status = st;
  end
endmodule

// File: tb/tb_rx_elastic_buf.sv
module tb_rx_elastic_buf;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       buf_rst = 1'b1, line_ok = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  wire  [7:0] rd_data, b_data;
  wire  [2:0] rd_status, b_status;

  rx_elastic_buf dut (
    .buf_rst(buf_rst), .wr_clk(clk), .line_ok(line_ok), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(clk), .rd_en(rd_en), .rd_data(rd_data), .rd_status(rd_status));

  rx_elastic_buf #(.BYPASS(1'b1)) byp (
    .buf_rst(buf_rst), .wr_clk(clk), .line_ok(line_ok), .wr_en(wr_en), .wr_data(wr_data),
    .rd_clk(clk), .rd_en(rd_en), .rd_data(b_data), .rd_status(b_status));

  localparam int MINL = 2, MAXL = 6, CENTER = 4;
  int checks = 0, errors = 0;

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset;
    buf_rst = 1'b1; step(2); buf_rst = 1'b0; step(6);
  endtask

  task automatic wr(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_data = 8'(base + i); wr_en = 1'b1; step(1);
    end
    wr_en = 1'b0;
  endtask

  task automatic rd(input int n);
    rd_en = 1'b1; step(n); rd_en = 1'b0;
  endtask

  initial begin
    step(3); buf_rst = 1'b0; step(6);
    chk(rd_status, 0, "R7 status after reset");
    chk(rd_data, 0, "R7 data after reset");

    for (int n = 0; n <= 8; n++) begin
      int exp;
      do_reset;
      if (n < CENTER) rd(CENTER - n); else wr(n - CENTER, 0);
      step(6);
      exp = (n < MINL) ? 1 : (n > MAXL) ? 2 : 0;
      chk(rd_status, exp, $sformatf("R1 R2 R3 level %0d", n));
    end

    do_reset; wr(4, 0); step(6);
    chk(rd_status, 2, "R3 full");
    wr(1, 0); step(6);
    chk(rd_status, 6, "R4 overflow over R3 threshold (R6)");
    rd(3); wr(2, 0); step(6);
    chk(rd_status, 6, "R4 overflow sticky");
    rd(10); step(6);
    chk(rd_status, 6, "R6 overflow wins over underflow");
    do_reset;
    chk(rd_status, 0, "R7 reset clears overflow");

    rd(4); step(6);
    chk(rd_status, 1, "R2 empty");
    rd(1); step(6);
    chk(rd_status, 5, "R5 underflow over R2 threshold (R6)");
    wr(2, 0); step(6);
    chk(rd_status, 5, "R5 underflow sticky");
    do_reset;
    chk(rd_status, 0, "R7 reset clears underflow");

    rd(4); step(6);
    for (int pass = 0; pass < 3; pass++) begin
      int base = 8'h30 + pass * 8'h20;
      wr(6, base); step(6);
      rd_en = 1'b1;
      for (int i = 0; i < 6; i++) begin
        step(1);
        chk(rd_data, (base + i) & 8'hFF, "R8 order");
      end
      rd_en = 1'b0; step(6);
      chk(rd_status, 1, "R8 drained without underflow");
    end

    do_reset; wr(5, 0); step(6);
    chk(rd_status, 6, "R9 overflow before idle");
    line_ok = 1'b0; step(5); line_ok = 1'b1; step(6);
    chk(rd_status, 6, "R10 short idle ignored");
    line_ok = 1'b0; step(20);
    chk(rd_status, 0, "R9 auto reset after idle");
    wr(5, 0); step(6);
    chk(rd_status, 6, "R10 overflow during same idle");
    step(30);
    chk(rd_status, 6, "R10 single reset per idle episode");
    line_ok = 1'b1; step(2);

    wr_data = 8'h5A; step(1);
    chk(b_data, 8'h5A, "R11 bypass data");
    wr_data = 8'hC3; step(1);
    chk(b_data, 8'hC3, "R11 bypass data");
    chk(b_status, 0, "R11 bypass status");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule